// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits behind a serial-bus slave and turns the bytes of one write transaction into a single commit to a small storage array. The slave reports three events. It reports the start of a write together with the target address. It reports each received data byte. It reports the end-of-transaction condition. The block latches the page part of the address and steps a small in-page offset for each byte. It records which page slots were filled, and when the transaction ends it copies the filled slots into the array all at once.

After a commit the block runs a programming interval of `PROG_CYCLES` clocks and raises `busy` for its whole length. The bus slave uses `busy` to stay silent. During that interval every write event and every array read is refused. The array is a plain register file, and there is a one-cycle registered read port next to the write path.

Top module: `pwb_seq`

## Requirements
- R1: Out of reset `busy` and `rd_ok` are 0, and every array location reads back as 0.
- R2: `wr_start` loads the page (address bits above the low `log2(PAGE_BYTES)` bits) and the offset (the low bits). Each `byte_vld` stores `byte_data` at page slot = current offset, and the next byte goes to the next slot.
- R3: Only the low offset bits advance. Starting at offset 2 with PAGE_BYTES=4, four bytes land at offsets 2, 3, 0, 1 of the same page, and the neighbouring page is untouched.
- R4: When more than PAGE_BYTES bytes arrive before the end event, the offset wraps and the later bytes overwrite earlier ones. With six bytes from offset 0, slots 0 and 1 hold bytes 5 and 6.
- R5: A commit writes only the slots filled in the current transaction. All other locations of the page keep their old contents.
- R6: An end event (`stop_evt`) with at least one filled slot commits the page and raises `busy` on the next cycle. `busy` stays high for exactly `PROG_CYCLES` cycles.
- R7: An end event with no filled slot does not raise `busy` and changes no array location.
- R8: While `busy` is high, `wr_start`, `byte_vld` and `stop_evt` are ignored. A byte offered during the interval is not committed later.
- R9: A read request (`rd_en`) while `busy` is low gives `rd_ok`=1 with the location's data one cycle later. While `busy` is high the request is refused and `rd_ok` is 0 one cycle later.
- R10: A byte strobe in the same cycle as the end event is part of the commit.
- R11: The filled-slot record clears at every commit. A later transaction to another page carries none of the earlier bytes.
- R12: A byte strobe in the same cycle as `wr_start` is stored at the new start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Start of a write transaction, qualifies `wr_addr` |
| wr_addr | input | ADDR_W | Start address of the write |
| byte_vld | input | 1 | One data byte received |
| byte_data | input | DATA_W | Received byte |
| stop_evt | input | 1 | End of the bus transaction |
| rd_en | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Read data, valid with `rd_ok` |
| rd_ok | output | 1 | Read accepted, data returned this cycle |
| busy | output | 1 | Programming interval in progress |

## Verification
Two events can coincide with the end event or the start event in the same cycle. A final byte strobe can arrive in the same cycle as `stop_evt`, and a first byte can arrive in the same cycle as `wr_start`. The bench drives both pairs on one clock edge. It judges the outcome by reading the array back after the programming interval: the merged final byte must be present, and the merged first byte must sit at the new start offset. A checker also ties every rising `busy` to an end event and checks the interval length with a counter.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic {
      PH_FILL = 1'b0,
      PH_PROG = 1'b1
   } pwb_phase_e;

endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 4,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int PG_W      = ADDR_W - OFF_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         accept,
   input  logic                         wr_start,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic                         byte_vld,
   input  logic [DATA_W-1:0]            byte_data,
   input  logic                         commit,
   output logic [PG_W-1:0]              nxt_page,
   output logic [PAGE_BYTES*DATA_W-1:0] nxt_data,
   output logic [PAGE_BYTES-1:0]        nxt_mask,
   output logic [PAGE_BYTES-1:0]        cur_mask
);

   localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);

   logic [PG_W-1:0]              page_q;
   logic [OFF_W-1:0]             off_q;
   logic [PAGE_BYTES-1:0]        mask_q;
   logic [PAGE_BYTES*DATA_W-1:0] data_q;

   logic                  st_take;
   logic                  bv_take;
   logic [OFF_W-1:0]      eff_off;
   logic [PAGE_BYTES-1:0] base_mask;

   always_comb begin
      st_take   = wr_start & accept;
      bv_take   = byte_vld & accept;
      eff_off   = st_take ? wr_addr[OFF_W-1:0] : off_q;
      nxt_page  = st_take ? wr_addr[ADDR_W-1:OFF_W] : page_q;
      base_mask = st_take ? '0 : mask_q;
   end

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
      logic hit;
      assign hit = bv_take && (eff_off == OFF_W'(g));
      assign nxt_data[g*DATA_W +: DATA_W] = hit ? byte_data : data_q[g*DATA_W +: DATA_W];
      assign nxt_mask[g] = base_mask[g] | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         off_q  <= '0;
         mask_q <= '0;
         data_q <= '0;
      end else begin
         page_q <= nxt_page;
         off_q  <= bv_take ? eff_off + OFF_ONE : eff_off;
         mask_q <= commit ? '0 : nxt_mask;
         data_q <= nxt_data;
      end
   end

   assign cur_mask = mask_q;

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer
   import pwb_pkg::*;
#(
   parameter int PROG_CYCLES = 12,
   localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy
);

   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

   pwb_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FILL;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_FILL: begin
               if (launch) begin
                  phase_q <= PH_PROG;
                  cnt_q   <= CNT_LOAD;
               end
            end
            PH_PROG: begin
               if (cnt_q == '0) phase_q <= PH_FILL;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: phase_q <= PH_FILL;
         endcase
      end
   end

   assign busy = (phase_q == PH_PROG);

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 4,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int PG_W      = ADDR_W - OFF_W,
   localparam int DEPTH     = 1 << ADDR_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit,
   input  logic [PG_W-1:0]              wr_page,
   input  logic [PAGE_BYTES*DATA_W-1:0] wr_data,
   input  logic [PAGE_BYTES-1:0]        wr_mask,
   input  logic                         rd_req,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         rd_ok
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      end else if (commit) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (wr_mask[i]) mem[{wr_page, OFF_W'(i)}] <= wr_data[i*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ok   <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ok <= rd_req;
         if (rd_req) rd_data <= mem[rd_addr];
      end
   end

endmodule

// File: rtl/pwb_seq.sv
module pwb_seq #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 4,
   parameter int PROG_CYCLES = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_evt,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_ok,
   output logic              busy
);

   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFF_W;

   if (PAGE_BYTES < 2 || (1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 1");
   end
   if (ADDR_W <= OFF_W || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must exceed the offset width and stay at or below 12");
   end

   logic [PG_W-1:0]              nxt_page;
   logic [PAGE_BYTES*DATA_W-1:0] nxt_data;
   logic [PAGE_BYTES-1:0]        nxt_mask;
   logic [PAGE_BYTES-1:0]        pg_mask;
   logic                         commit;

   assign commit = stop_evt && !busy && (|nxt_mask);

   pwb_page_buf #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .accept(!busy),
      .wr_start(wr_start), .wr_addr(wr_addr),
      .byte_vld(byte_vld), .byte_data(byte_data),
      .commit(commit),
      .nxt_page(nxt_page), .nxt_data(nxt_data), .nxt_mask(nxt_mask),
      .cur_mask(pg_mask)
   );

   pwb_prog_timer #(
      .PROG_CYCLES(PROG_CYCLES)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n), .launch(commit), .busy(busy)
   );

   pwb_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .wr_page(nxt_page), .wr_data(nxt_data), .wr_mask(nxt_mask),
      .rd_req(rd_en && !busy), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_ok(rd_ok)
   );

endmodule

// File: rtl/pwb_seq_chk.sv
module pwb_seq_chk #(
   parameter int PAGE_BYTES  = 4,
   parameter int PROG_CYCLES = 12,
   localparam int BC_W       = $clog2(PROG_CYCLES + 2)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  stop_evt,
   input logic                  byte_vld,
   input logic                  rd_en,
   input logic                  rd_ok,
   input logic                  busy,
   input logic [PAGE_BYTES-1:0] pg_mask
);

   logic [BC_W-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
      else           bcnt <= '0;
   end

   // R6
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));

   // R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (bcnt == BC_W'(PROG_CYCLES)));

   // R6
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bcnt < BC_W'(PROG_CYCLES)));

   // R7
   empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && !busy && !byte_vld && pg_mask == '0) |=> !busy);

   // R9
   rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy) |=> !rd_ok);

   // R9
   rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !busy) |=> rd_ok);

   // R11
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (pg_mask == '0));

endmodule

bind pwb_seq pwb_seq_chk #(
   .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .byte_vld(byte_vld),
   .rd_en(rd_en), .rd_ok(rd_ok), .busy(busy), .pg_mask(pg_mask)
);

// File: tb/sim_pwb_seq.sv
`timescale 1ns/1ps
module sim_pwb_seq;

   localparam int AW   = 8;
   localparam int DW   = 8;
   localparam int PB   = 4;
   localparam int PROG = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_start = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic          byte_vld = 1'b0;
   logic [DW-1:0] byte_data = '0;
   logic          stop_evt = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          rd_ok;
   logic          busy;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [1 << AW];

   always #5 clk = ~clk;

   pwb_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .PROG_CYCLES(PROG)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
      .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok),
      .busy(busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input int addr, input string req);
      rd_en = 1'b1; rd_addr = AW'(addr);
      @(negedge clk);
      rd_en = 1'b0;
      chk({req, " rd_ok"}, int'(rd_ok), 1);
      chk({req, " rd_data"}, int'(rd_data), int'(model[addr]));
   endtask

   // Expected array contents per R2..R4 (page fixed, offset steps modulo PB)
   task automatic model_txn(input int addr, input int n, input int d0);
      int page = addr / PB;
      int off  = addr % PB;
      for (int k = 0; k < n; k++) begin
         model[page*PB + off] = DW'(d0 + k);
         off = (off + 1) % PB;
      end
   endtask

   task automatic txn(input int addr, input int n, input int d0, input bit merge_stop);
      wr_start = 1'b1; wr_addr = AW'(addr);
      @(negedge clk);
      wr_start = 1'b0;
      for (int k = 0; k < n; k++) begin
         byte_vld = 1'b1; byte_data = DW'(d0 + k);
         if (merge_stop && k == n - 1) stop_evt = 1'b1;
         @(negedge clk);
      end
      byte_vld = 1'b0;
      if (!merge_stop) begin
         stop_evt = 1'b1;
         @(negedge clk);
      end
      stop_evt = 1'b0;
      model_txn(addr, n, d0);
   endtask

   task automatic wait_prog(input string req);
      int n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
      chk({req, " busy length"}, n, PROG);
   endtask

   task automatic t_reset;
      chk("R1 busy", int'(busy), 0);
      chk("R1 rd_ok", int'(rd_ok), 0);
      rd(8'h05, "R1");
      rd(8'hFF, "R1");
   endtask

   task automatic t_single;
      txn(8'h10, 1, 8'hA5, 1'b0);
      chk("R6 busy raised", int'(busy), 1);
      wait_prog("R6");
      rd(8'h10, "R2");
      rd(8'h11, "R5");
      rd(8'h13, "R5");
   endtask

   task automatic t_wrap;
      txn(8'h22, 4, 8'h31, 1'b0);
      wait_prog("R3");
      for (int a = 8'h20; a < 8'h24; a++) rd(a, "R3");
      rd(8'h24, "R3 next page");
      rd(8'h1F, "R3 prev page");
   endtask

   task automatic t_over;
      txn(8'h40, 6, 8'h61, 1'b0);
      wait_prog("R4");
      chk("R4 model slot0", int'(model[8'h40]), 8'h65);
      for (int a = 8'h40; a < 8'h44; a++) rd(a, "R4");
   endtask

   task automatic t_empty;
      wr_start = 1'b1; wr_addr = 8'h50;
      @(negedge clk);
      wr_start = 1'b0; stop_evt = 1'b1;
      @(negedge clk);
      stop_evt = 1'b0;
      chk("R7 no busy", int'(busy), 0);
      @(negedge clk);
      chk("R7 no busy later", int'(busy), 0);
      rd(8'h50, "R7");
   endtask

   task automatic t_busy_ignore;
      txn(8'h60, 1, 8'h77, 1'b0);
      rd_en = 1'b1; rd_addr = 8'h60;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R9 refused read", int'(rd_ok), 0);
      wr_start = 1'b1; wr_addr = 8'h61; byte_vld = 1'b1; byte_data = 8'hEE;
      @(negedge clk);
      wr_start = 1'b0; byte_vld = 1'b0; stop_evt = 1'b1;
      @(negedge clk);
      stop_evt = 1'b0;
      while (busy) @(negedge clk);
      stop_evt = 1'b1;
      @(negedge clk);
      stop_evt = 1'b0;
      chk("R8 late stop no busy", int'(busy), 0);
      rd(8'h60, "R8");
      rd(8'h61, "R8");
   endtask

   task automatic t_same_stop;
      txn(8'h70, 2, 8'h91, 1'b1);
      chk("R10 busy raised", int'(busy), 1);
      wait_prog("R10");
      rd(8'h70, "R10");
      rd(8'h71, "R10");
   endtask

   task automatic t_same_start;
      wr_start = 1'b1; wr_addr = 8'h33; byte_vld = 1'b1; byte_data = 8'h5C;
      @(negedge clk);
      wr_start = 1'b0; byte_vld = 1'b0; stop_evt = 1'b1;
      @(negedge clk);
      stop_evt = 1'b0;
      model[8'h33] = 8'h5C;
      wait_prog("R12");
      rd(8'h33, "R12");
      rd(8'h30, "R12");
   endtask

   task automatic t_mask_clear;
      txn(8'h80, 4, 8'hC1, 1'b0);
      wait_prog("R11");
      txn(8'h85, 1, 8'hD7, 1'b0);
      wait_prog("R11");
      for (int a = 8'h84; a < 8'h88; a++) rd(a, "R11");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int a = 0; a < (1 << AW); a++) model[a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_wrap();
      t_over();
      t_empty();
      t_busy_ignore();
      t_same_stop();
      t_same_start();
      t_mask_clear();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule